// File: doc/BRIEF.md
# Multi-Channel Pulse-Width Modulator

This block drives a set of independent pulse-width modulated outputs from a single reference clock. Each channel has its own configuration: an 8-bit clock divider that sets the tick rate, an 18-bit high-time count, an 18-bit cycle length and an output inversion flag. Software reaches every setting through a flat register port of 16-bit words at 4-byte address steps. Because a count is wider than one word, it is split: the low 16 bits sit at one address and the top 2 bits sit at the next word up.

Channels are switched on and off through one shared hold register, which has one bit per channel. A set bit freezes that channel at its idle level and clears its counters. After reset every hold bit is clear, so every channel is running. New count or divider values are staged and only take effect at the end of the cycle that is running when they are written, so an output never shows a cycle built from a mix of old and new settings.

Top module: `pwm_bank`

## Requirements
- R1: Channel c owns the addresses c×0x80 + {0x08, 0x0C} for the high time (bits 15:0, then bits 17:16 in data bits 1:0) and c×0x80 + {0x10, 0x14} for the cycle length, split the same way. A read returns the last written value, and unused upper data bits of the top-half words read as 0.
- R2: The divider is bits 7:0 at c×0x80 + 0x18. With divider value k the channel counter advances once every k+1 reference clocks.
- R3: The channel counter runs from 0 to P−1 and then wraps to 0, where P is the cycle length and P=0 behaves as one tick. With normal polarity the output is high while the counter is below the high time D. The first tick after a channel is released starts at counter 0.
- R4: Bit 4 of the control word at c×0x80 + 0x1C inverts that channel's output, and it reads back.
- R5: The hold register at 0x1FC has bit c for channel c. While the bit is 1, that channel's counter and divider are cleared and its output sits at the idle level: low, or high when the channel is inverted.
- R6: After reset all registers read 0, every hold bit is 0 and every output is low.
- R7: A high time of D ≥ P with D > 0 keeps the output constantly active. D = 0 keeps it constantly idle.
- R8: High time, cycle length and divider written while a channel runs take effect only at the next cycle boundary. A channel released from hold starts with the values programmed at that moment.
- R9: Addresses outside the map, including channels at or above the channel count, offsets that are not listed and addresses that are not word aligned, read as 0, and writes to them change no register.
- R10: Channels run independently: holding or reprogramming one channel does not disturb another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe, sampled on the rising edge of clk |
| reg_addr | input | ADDR_W | Byte address for reads and writes |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr (combinational) |
| pwm_o | output | NUM_CH | One modulated output per channel |

## Verification
The bench builds the four-channel configuration and keeps the default 10-bit address. That leaves the groups at 0x200 and above addressable but unmapped, which puts the out-of-range channel decode of R9 within reach of ordinary writes and reads. Divider values above zero, cycle lengths of a few ticks and high times at zero, inside the cycle and beyond it cover R2, R3 and R7 through counts of high samples over whole cycles. A duty rewrite in the middle of a cycle shows the staged update of R8.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

   // address layout of one channel group
   localparam int GRP_W      = 7;            // group spans 2**GRP_W bytes
   localparam int OFS_HI_LO  = 8'h08;
   localparam int OFS_HI_UP  = 8'h0C;
   localparam int OFS_CYC_LO = 8'h10;
   localparam int OFS_CYC_UP = 8'h14;
   localparam int OFS_DIV    = 8'h18;
   localparam int OFS_CTRL   = 8'h1C;
   localparam int HOLD_ADDR  = 12'h1FC;
   localparam int INV_BIT    = 4;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_HI_LO,
      SEL_HI_UP,
      SEL_CYC_LO,
      SEL_CYC_UP,
      SEL_DIV,
      SEL_CTRL,
      SEL_HOLD
   } reg_sel_e;

   function automatic reg_sel_e group_sel(input logic [GRP_W-1:0] ofs);
      reg_sel_e s;
      case (int'(ofs))
         OFS_HI_LO:  s = SEL_HI_LO;
         OFS_HI_UP:  s = SEL_HI_UP;
         OFS_CYC_LO: s = SEL_CYC_LO;
         OFS_CYC_UP: s = SEL_CYC_UP;
         OFS_DIV:    s = SEL_DIV;
         OFS_CTRL:   s = SEL_CTRL;
         default:    s = SEL_NONE;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/pwm_regfile.sv
module pwm_regfile
   import pwm_bank_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int ADDR_W = 10,
   parameter int DATA_W = 16,
   parameter int CNT_W  = 18,
   parameter int DIV_W  = 8
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              wr,
   input  logic [ADDR_W-1:0]                 addr,
   input  logic [DATA_W-1:0]                 wdata,
   output logic [DATA_W-1:0]                 rdata,
   output logic [NUM_CH-1:0][CNT_W-1:0]      hi_cnt,
   output logic [NUM_CH-1:0][CNT_W-1:0]      cyc_cnt,
   output logic [NUM_CH-1:0][DIV_W-1:0]      div_val,
   output logic [NUM_CH-1:0]                 inv,
   output logic [NUM_CH-1:0]                 hold
);

   localparam int UP_W = CNT_W - DATA_W;
   localparam int CH_W = ADDR_W - GRP_W;
   localparam int CH_IW = $clog2(NUM_CH);

   logic [CH_W-1:0]  ch_full;
   logic [CH_IW-1:0] ch_idx;
   logic             ch_hit;
   reg_sel_e         sel;

   assign ch_full = addr[ADDR_W-1:GRP_W];
   assign ch_idx  = ch_full[CH_IW-1:0];
   assign ch_hit  = int'(ch_full) < NUM_CH;

   always_comb begin
      if (int'(addr) == HOLD_ADDR)
         sel = SEL_HOLD;
      else if (ch_hit)
         sel = group_sel(addr[GRP_W-1:0]);
      else
         sel = SEL_NONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_cnt  <= '0;
         cyc_cnt <= '0;
         div_val <= '0;
         inv     <= '0;
         hold    <= '0;
      end else if (wr) begin
         if (sel == SEL_HOLD)
            hold <= wdata[NUM_CH-1:0];
         for (int c = 0; c < NUM_CH; c++) begin
            if (ch_idx == CH_IW'(c)) begin
               case (sel)
                  SEL_HI_LO:  hi_cnt[c][DATA_W-1:0]      <= wdata;
                  SEL_HI_UP:  hi_cnt[c][CNT_W-1:DATA_W]  <= wdata[UP_W-1:0];
                  SEL_CYC_LO: cyc_cnt[c][DATA_W-1:0]     <= wdata;
                  SEL_CYC_UP: cyc_cnt[c][CNT_W-1:DATA_W] <= wdata[UP_W-1:0];
                  SEL_DIV:    div_val[c]                 <= wdata[DIV_W-1:0];
                  SEL_CTRL:   inv[c]                     <= wdata[INV_BIT];
                  default: ;
               endcase
            end
         end
      end
   end

   always_comb begin
      rdata = '0;
      case (sel)
         SEL_HI_LO:  rdata             = hi_cnt[ch_idx][DATA_W-1:0];
         SEL_HI_UP:  rdata[UP_W-1:0]   = hi_cnt[ch_idx][CNT_W-1:DATA_W];
         SEL_CYC_LO: rdata             = cyc_cnt[ch_idx][DATA_W-1:0];
         SEL_CYC_UP: rdata[UP_W-1:0]   = cyc_cnt[ch_idx][CNT_W-1:DATA_W];
         SEL_DIV:    rdata[DIV_W-1:0]  = div_val[ch_idx];
         SEL_CTRL:   rdata[INV_BIT]    = inv[ch_idx];
         SEL_HOLD:   rdata[NUM_CH-1:0] = hold;
         default: ;
      endcase
   end

endmodule

// File: rtl/pwm_tick.sv
module pwm_tick #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hold,
   input  logic [DIV_W-1:0] limit,
   output logic             tick
);

   logic [DIV_W-1:0] pre_q;

   assign tick = (pre_q == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pre_q <= '0;
      else if (hold || tick)
         pre_q <= '0;
      else
         pre_q <= pre_q + 1'b1;
   end

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
   parameter int CNT_W = 18,
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hold,
   input  logic             inv,
   input  logic [CNT_W-1:0] cfg_hi,
   input  logic [CNT_W-1:0] cfg_cyc,
   input  logic [DIV_W-1:0] cfg_div,
   output logic             pwm,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] act_hi_o,
   output logic [CNT_W-1:0] act_cyc_o,
   output logic             bound_o
);

   logic [CNT_W-1:0] cnt_q, act_hi_q, act_cyc_q;
   logic [DIV_W-1:0] act_div_q;
   logic             tick, last;

   pwm_tick #(.DIV_W(DIV_W)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .hold  (hold),
      .limit (act_div_q),
      .tick  (tick)
   );

   assign last    = ({1'b0, cnt_q} + 1'b1) >= {1'b0, act_cyc_q};
   assign bound_o = tick && last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         act_hi_q  <= '0;
         act_cyc_q <= '0;
         act_div_q <= '0;
      end else if (hold || bound_o) begin
         cnt_q     <= '0;
         act_hi_q  <= cfg_hi;
         act_cyc_q <= cfg_cyc;
         act_div_q <= cfg_div;
      end else if (tick) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign pwm       = hold ? inv : ((cnt_q < act_hi_q) ^ inv);
   assign cnt_o     = cnt_q;
   assign act_hi_o  = act_hi_q;
   assign act_cyc_o = act_cyc_q;

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank #(
   parameter int NUM_CH = 8,
   parameter int ADDR_W = 10,
   parameter int DATA_W = 16,
   parameter int CNT_W  = 18,
   parameter int DIV_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic [NUM_CH-1:0] pwm_o
);

   localparam int MAP_BYTES = NUM_CH * (1 << pwm_bank_pkg::GRP_W);

   if (NUM_CH != 4 && NUM_CH != 8) begin : g_bad_ch
      $error("pwm_bank: NUM_CH must be 4 or 8");
   end
   if ((1 << ADDR_W) < MAP_BYTES || (1 << ADDR_W) <= pwm_bank_pkg::HOLD_ADDR) begin : g_bad_addr
      $error("pwm_bank: ADDR_W too narrow for the register map");
   end
   if (CNT_W <= DATA_W || CNT_W > 2 * DATA_W) begin : g_bad_cnt
      $error("pwm_bank: CNT_W must span more than one and at most two words");
   end
   if (DIV_W > DATA_W || DATA_W <= pwm_bank_pkg::INV_BIT) begin : g_bad_div
      $error("pwm_bank: DIV_W or DATA_W out of range");
   end

   logic [NUM_CH-1:0][CNT_W-1:0] cfg_hi, cfg_cyc, ch_cnt, ch_act_hi, ch_act_cyc;
   logic [NUM_CH-1:0][DIV_W-1:0] cfg_div;
   logic [NUM_CH-1:0]            ch_inv, ch_hold, ch_bound;

   pwm_regfile #(
      .NUM_CH (NUM_CH),
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W),
      .DIV_W  (DIV_W)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (reg_wr),
      .addr    (reg_addr),
      .wdata   (reg_wdata),
      .rdata   (reg_rdata),
      .hi_cnt  (cfg_hi),
      .cyc_cnt (cfg_cyc),
      .div_val (cfg_div),
      .inv     (ch_inv),
      .hold    (ch_hold)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      pwm_chan #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .hold      (ch_hold[c]),
         .inv       (ch_inv[c]),
         .cfg_hi    (cfg_hi[c]),
         .cfg_cyc   (cfg_cyc[c]),
         .cfg_div   (cfg_div[c]),
         .pwm       (pwm_o[c]),
         .cnt_o     (ch_cnt[c]),
         .act_hi_o  (ch_act_hi[c]),
         .act_cyc_o (ch_act_cyc[c]),
         .bound_o   (ch_bound[c])
      );
   end

endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk #(
   parameter int NUM_CH = 8,
   parameter int CNT_W  = 18
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic [NUM_CH-1:0]            hold,
   input logic [NUM_CH-1:0]            inv,
   input logic [NUM_CH-1:0]            pwm,
   input logic [NUM_CH-1:0][CNT_W-1:0] cnt,
   input logic [NUM_CH-1:0][CNT_W-1:0] act_hi,
   input logic [NUM_CH-1:0][CNT_W-1:0] act_cyc,
   input logic [NUM_CH-1:0]            bound
);

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
      // R5: a channel held for two cycles sits at its idle level
      assert_idle_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
         hold[c] && $past(hold[c]) |-> pwm[c] == inv[c]);

      // R3: the counter stays inside the active cycle length
      assert_cnt_in_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
         !hold[c] && act_cyc[c] != '0 |-> cnt[c] < act_cyc[c]);

      // R3: release from hold starts at counter zero
      assert_release_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(hold[c]) |-> cnt[c] == '0);

      // R8: staged values only move at a boundary or under hold
      assert_staged_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
         !$past(bound[c]) && !$past(hold[c]) |-> $stable(act_hi[c]) && $stable(act_cyc[c]));

      // R7: high time at or above cycle length keeps the output active
      assert_full_active_R7: assert property (@(posedge clk) disable iff (!rst_n)
         !hold[c] && act_hi[c] != '0 && act_hi[c] >= act_cyc[c] |-> pwm[c] == !inv[c]);

      // R7: zero high time keeps the output idle
      assert_zero_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
         act_hi[c] == '0 |-> pwm[c] == inv[c]);
   end

endmodule

bind pwm_bank pwm_bank_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .hold    (ch_hold),
   .inv     (ch_inv),
   .pwm     (pwm_o),
   .cnt     (ch_cnt),
   .act_hi  (ch_act_hi),
   .act_cyc (ch_act_cyc),
   .bound   (ch_bound)
);

// File: tb/tb_pwm_bank.sv
`timescale 1ns/1ps
module tb_pwm_bank;

   localparam int NCH = 4;
   localparam int AW  = 10;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           reg_wr = 1'b0;
   logic [AW-1:0]  reg_addr = '0;
   logic [15:0]    reg_wdata = '0;
   logic [15:0]    reg_rdata;
   logic [NCH-1:0] pwm_o;

   int tests = 0;
   int fails = 0;
   logic [NCH-1:0] hold_mask = '0;

   always #5 clk = ~clk;

   pwm_bank #(.NUM_CH(NCH), .ADDR_W(AW)) dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .pwm_o     (pwm_o)
   );

   task automatic check(input string req, input int got, input int exp);
      tests++;
      if (got != exp) begin
         fails++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      reg_addr  = AW'(a);
      reg_wdata = 16'(d);
      reg_wr    = 1'b1;
      @(negedge clk);
      reg_wr    = 1'b0;
   endtask

   task automatic rd(input int a, output int d);
      @(negedge clk);
      reg_addr = AW'(a);
      #1;
      d = int'(reg_rdata);
   endtask

   task automatic measure(input int ch, input int n, output int highs);
      highs = 0;
      for (int i = 0; i < n; i++) begin
         if (pwm_o[ch]) highs++;
         @(negedge clk);
      end
   endtask

   // hold a channel, program it, release it; returns at counter 0
   task automatic start_ch(input int ch, input int hi, input int cyc, input int dv, input int iv);
      hold_mask[ch] = 1'b1;
      wr('h1FC, int'(hold_mask));
      wr(ch * 'h80 + 'h08, hi & 'hFFFF);
      wr(ch * 'h80 + 'h0C, hi >> 16);
      wr(ch * 'h80 + 'h10, cyc & 'hFFFF);
      wr(ch * 'h80 + 'h14, cyc >> 16);
      wr(ch * 'h80 + 'h18, dv);
      wr(ch * 'h80 + 'h1C, iv << 4);
      hold_mask[ch] = 1'b0;
      wr('h1FC, int'(hold_mask));
   endtask

   task automatic t_reset();
      int d;
      rd('h1FC, d);        check("R6 hold reg", d, 0);
      rd('h08, d);         check("R6 duty lo", d, 0);
      rd('h18 + 'h80, d);  check("R6 divider", d, 0);
      check("R6 outputs", int'(pwm_o), 0);
   endtask

   task automatic t_split();
      int d;
      wr('h80 + 'h08, 'hABCD);
      wr('h80 + 'h0C, 'h0002);
      rd('h80 + 'h08, d); check("R1 duty low half", d, 'hABCD);
      rd('h80 + 'h0C, d); check("R1 duty top bits", d, 2);
      wr('h80 + 'h14, 'hFFFF);
      rd('h80 + 'h14, d); check("R1 period top masked", d, 3);
   endtask

   task automatic t_basic();
      int h;
      start_ch(0, 3, 10, 0, 0);
      check("R3 first sample high", int'(pwm_o[0]), 1);
      measure(0, 20, h); check("R3 highs in two cycles", h, 6);
   endtask

   task automatic t_div();
      int h;
      start_ch(0, 1, 4, 2, 0);
      measure(0, 24, h); check("R2 divided highs", h, 6);
   endtask

   task automatic t_inv();
      int h, d;
      start_ch(0, 3, 10, 0, 1);
      measure(0, 20, h); check("R4 inverted highs", h, 14);
      rd('h1C, d); check("R4 readback", d, 'h10);
   endtask

   task automatic t_hold();
      int h;
      hold_mask[0] = 1'b1;
      wr('h1FC, int'(hold_mask));
      measure(0, 8, h); check("R5 idle high when inverted", h, 8);
      wr('h1C, 0);
      measure(0, 8, h); check("R5 idle low", h, 0);
   endtask

   task automatic t_extremes();
      int h;
      start_ch(0, 12, 10, 0, 0);
      measure(0, 20, h); check("R7 duty beyond period", h, 20);
      start_ch(0, 0, 10, 0, 0);
      measure(0, 20, h); check("R7 zero duty", h, 0);
   endtask

   task automatic t_staged();
      int h;
      start_ch(0, 3, 10, 0, 0);
      measure(0, 5, h); check("R8 before rewrite", h, 3);
      wr('h08, 8);
      measure(0, 13, h); check("R8 rewrite waits for boundary", h, 8);
   endtask

   task automatic t_unmapped();
      int d;
      wr('h208, 'h1234);
      rd('h208, d); check("R9 channel out of range", d, 0);
      wr('h00A, 'h5555);
      rd('h00A, d); check("R9 misaligned", d, 0);
      rd('h000, d); check("R9 unlisted offset", d, 0);
      rd('h88, d);  check("R9 neighbour intact", d, 'hABCD);
   endtask

   task automatic t_indep();
      int h;
      hold_mask[0] = 1'b1;
      wr('h1FC, int'(hold_mask));
      start_ch(2, 2, 6, 0, 0);
      measure(2, 12, h); check("R10 ch2 highs", h, 4);
      check("R10 ch0 still idle", int'(pwm_o[0]), 0);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      fails++; tests++;
      $display("FAIL watchdog expired: got 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_split();
      t_basic();
      t_div();
      t_inv();
      t_hold();
      t_extremes();
      t_staged();
      t_unmapped();
      t_indep();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule